// File: doc/BRIEF.md
# Overlay Text Line Pixel Serializer

This block turns one scan line of an on-screen text overlay into a 1-bit pixel stream, one pixel per clock. The line holds a fixed number of character slots. Each slot is either a glyph cell or a mark cell. A glyph cell emits the 5-bit row slice of its character, leftmost pixel first, followed by two dark pixels. A mark cell emits one pixel taken from a small per-line mark field, followed by two dark pixels. The first group of slots, by default the eleven cells of a day-month-year field, is sent first at the left. A dark span of programmable length follows. The second group, by default eight digits and three separators of a clock field, then fills the right side.

A line request is a valid/ready handshake. The requester holds `line_valid` together with every glyph slice, the mark-slot flags, the mark field and the blank length. The request is taken on a clock edge where both `line_valid` and `line_ready` are high, and all of these inputs are copied at that edge. `line_ready` stays low from the accepting edge until the line is finished, so the block applies back-pressure for the whole line. A request offered while `line_ready` is low is neither taken nor queued. The pixel output has no back-pressure, because a video line cannot stall. `line_done` is a plain status pulse.

Top module: `ovl_glyph_serializer`

## Requirements
- R1: After reset `pix_out` is 0, `line_ready` is 1 and `line_done` is 0.
- R2: A glyph slot (its `slot_is_mark` bit is 0) occupies 7 clocks. Its 5-bit slice in `glyph_rows[s*5 +: 5]` is sent bit 4 first and bit 0 last, and then two 0 pixels follow.
- R3: A mark slot (its `slot_is_mark` bit is 1) occupies 3 clocks: one mark pixel and then two 0 pixels. Mark slots take their pixels from `mark_row` in slot order. The first mark slot uses bit 2, the second uses bit 1 and the third uses bit 0.
- R4: The first pixel of slot 0 appears in the clock cycle right after the accepting edge. Slots are then sent in increasing index with no idle cycles, apart from the blank span in R5.
- R5: After the last slot of the first group (slot 10), `pix_out` is 0 for exactly `blank_len` clocks before slot 11 starts. A `blank_len` of 0 inserts no blank.
- R6: `pix_out` is 0 whenever no line is being sent, including after the final cell.
- R7: `line_done` is high for exactly one cycle, the cycle after the final pixel, and `line_ready` is high again in that same cycle.
- R8: While `line_ready` is low, `line_valid` has no effect. The line in flight keeps its pixels and its length.
- R9: Changes on the data inputs after the accepting edge do not alter the line in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_valid | input | 1 | Line request valid |
| line_ready | output | 1 | Block idle, request can be taken |
| glyph_rows | input | 110 | 22 slices of 5 bits, slot s at bits s*5+4..s*5 |
| slot_is_mark | input | 22 | Bit s set marks slot s as a 3-pixel mark cell |
| mark_row | input | 3 | Mark pixels for this scan line, used from bit 2 down |
| blank_len | input | 8 | Dark clocks between the two groups |
| pix_out | output | 1 | Serial pixel |
| line_done | output | 1 | One-cycle pulse after the final pixel |

## Verification
Wrong internal state shows up on `pix_out` as a shift within a few pixels. A cell counter that ends one clock early or late moves every later pixel by one position and changes the line length. A wrong mark index puts the wrong separator bit into the clock field. A bad blank counter displaces the whole right group and moves `line_done` by the same amount. The bench compares every pixel position of each line against a stream it builds from the requirements. Because of that, a wrong state is reported on the first pixel where it diverges, and the timing of `line_done` and `line_ready` exposes any change in line length.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CELL  = 2'd1,
    ST_BLANK = 2'd2
  } ovl_state_e;
endpackage

// File: rtl/ovl_line_regs.sv
module ovl_line_regs #(
  parameter int NSLOT = 22,
  parameter int GW    = 5,
  parameter int NMARK = 3,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NSLOT*GW-1:0] glyph_in,
  input  logic [NSLOT-1:0]    mark_sel_in,
  input  logic [NMARK-1:0]    mark_row_in,
  input  logic [BW-1:0]       blank_in,
  output logic [NSLOT*GW-1:0] glyph_q,
  output logic [NSLOT-1:0]    mark_sel_q,
  output logic [NMARK-1:0]    mark_row_q,
  output logic [BW-1:0]       blank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glyph_q    <= '0;
      mark_sel_q <= '0;
      mark_row_q <= '0;
      blank_q    <= '0;
    end else if (load) begin
      glyph_q    <= glyph_in;
      mark_sel_q <= mark_sel_in;
      mark_row_q <= mark_row_in;
      blank_q    <= blank_in;
    end
  end
endmodule

// File: rtl/ovl_cell_timer.sv
module ovl_cell_timer
  import ovl_pkg::*;
#(
  parameter int NSLOT      = 22,
  parameter int DATE_SLOTS = 11,
  parameter int GW         = 5,
  parameter int GAP        = 2,
  parameter int NMARK      = 3,
  parameter int BW         = 8,
  localparam int SLW = $clog2(NSLOT),
  localparam int PXW = $clog2(GW + GAP),
  localparam int MIW = $clog2(NMARK + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cur_mark,
  input  logic [BW-1:0]  blank_len,
  output ovl_state_e     state,
  output logic [SLW-1:0] slot,
  output logic [PXW-1:0] px,
  output logic [MIW-1:0] midx,
  output logic           done
);
  localparam logic [SLW-1:0] LAST_SLOT  = SLW'(NSLOT - 1);
  localparam logic [SLW-1:0] BREAK_SLOT = SLW'(DATE_SLOTS - 1);
  localparam logic [PXW-1:0] LAST_GLYPH = PXW'(GW + GAP - 1);
  localparam logic [PXW-1:0] LAST_MARK  = PXW'(GAP);
  localparam logic [MIW-1:0] MIDX_TOP   = MIW'(NMARK);

  logic [BW-1:0] bcnt;
  logic          cell_last;

  assign cell_last = (px == (cur_mark ? LAST_MARK : LAST_GLYPH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
      px    <= '0;
      midx  <= '0;
      bcnt  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_CELL;
          slot  <= '0;
          px    <= '0;
          midx  <= '0;
        end
        ST_CELL: begin
          if (!cell_last) begin
            px <= px + 1'b1;
          end else begin
            px <= '0;
            if (cur_mark && midx != MIDX_TOP) midx <= midx + 1'b1;
            if (slot == LAST_SLOT) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
              if (slot == BREAK_SLOT && blank_len != '0) begin
                state <= ST_BLANK;
                bcnt  <= '0;
              end
            end
          end
        end
        ST_BLANK: begin
          if (BW'(bcnt + 1'b1) == blank_len) state <= ST_CELL;
          else bcnt <= bcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CELL && !cell_last) |=> (state == ST_CELL && slot == $past(slot)));
  // R5
  blank_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLANK) |=> (state != ST_IDLE));
endmodule

// File: rtl/ovl_pixel_pick.sv
module ovl_pixel_pick
  import ovl_pkg::*;
#(
  parameter int GW    = 5,
  parameter int GAP   = 2,
  parameter int NMARK = 3,
  localparam int PXW = $clog2(GW + GAP),
  localparam int MIW = $clog2(NMARK + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ovl_state_e     state,
  input  logic [PXW-1:0] px,
  input  logic [MIW-1:0] midx,
  input  logic [GW-1:0]  cur_row,
  input  logic           cur_mark,
  input  logic [NMARK-1:0] mark_row,
  output logic           pix
);
  always_comb begin
    pix = 1'b0;
    if (state == ST_CELL) begin
      if (cur_mark) begin
        if (px == '0) begin
          for (int m = 0; m < NMARK; m++)
            if (midx == MIW'(m)) pix = mark_row[NMARK-1-m];
        end
      end else begin
        for (int b = 0; b < GW; b++)
          if (px == PXW'(GW - 1 - b)) pix = cur_row[b];
      end
    end
  end

  // R6
  dark_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !pix);
  // R5
  dark_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLANK) |-> !pix);
  // R2
  glyph_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CELL && !cur_mark && px >= PXW'(GW)) |-> !pix);
  // R3
  mark_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CELL && cur_mark && px != '0) |-> !pix);
endmodule

// File: rtl/ovl_glyph_serializer.sv
module ovl_glyph_serializer
  import ovl_pkg::*;
#(
  parameter int NSLOT      = 22,
  parameter int DATE_SLOTS = 11,
  parameter int GW         = 5,
  parameter int GAP        = 2,
  parameter int NMARK      = 3,
  parameter int BW         = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_valid,
  output logic                line_ready,
  input  logic [NSLOT*GW-1:0] glyph_rows,
  input  logic [NSLOT-1:0]    slot_is_mark,
  input  logic [NMARK-1:0]    mark_row,
  input  logic [BW-1:0]       blank_len,
  output logic                pix_out,
  output logic                line_done
);
  localparam int SLW = $clog2(NSLOT);
  localparam int PXW = $clog2(GW + GAP);
  localparam int MIW = $clog2(NMARK + 1);

  ovl_state_e          state;
  logic [SLW-1:0]      slot;
  logic [PXW-1:0]      px;
  logic [MIW-1:0]      midx;
  logic [NSLOT*GW-1:0] glyph_q;
  logic [NSLOT-1:0]    mark_sel_q;
  logic [NMARK-1:0]    mark_row_q;
  logic [BW-1:0]       blank_q;
  logic [GW-1:0]       cur_row;
  logic                cur_mark;
  logic                accept;

  assign line_ready = (state == ST_IDLE);
  assign accept     = line_valid && line_ready;

  ovl_line_regs #(.NSLOT(NSLOT), .GW(GW), .NMARK(NMARK), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .glyph_in(glyph_rows), .mark_sel_in(slot_is_mark),
    .mark_row_in(mark_row), .blank_in(blank_len),
    .glyph_q(glyph_q), .mark_sel_q(mark_sel_q),
    .mark_row_q(mark_row_q), .blank_q(blank_q)
  );

  always_comb begin
    cur_row  = '0;
    cur_mark = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot == SLW'(s)) begin
        cur_row  = glyph_q[s*GW +: GW];
        cur_mark = mark_sel_q[s];
      end
    end
  end

  ovl_cell_timer #(.NSLOT(NSLOT), .DATE_SLOTS(DATE_SLOTS), .GW(GW), .GAP(GAP),
                   .NMARK(NMARK), .BW(BW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .cur_mark(cur_mark),
    .blank_len(blank_q), .state(state), .slot(slot), .px(px),
    .midx(midx), .done(line_done)
  );

  ovl_pixel_pick #(.GW(GW), .GAP(GAP), .NMARK(NMARK)) u_pick (
    .clk(clk), .rst_n(rst_n), .state(state), .px(px), .midx(midx),
    .cur_row(cur_row), .cur_mark(cur_mark), .mark_row(mark_row_q),
    .pix(pix_out)
  );

  // R7
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> line_ready);
  // R4
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !line_ready);
endmodule

// File: tb/test_ovl_glyph_serializer.sv
module test_ovl_glyph_serializer;
  localparam int NSLOT = 22;
  localparam int GW    = 5;
  localparam int NV    = 4;
  localparam int V_SEED  [NV] = '{3, 17, 90, 201};
  localparam int V_MARK  [NV] = '{5, 2, 7, 0};
  localparam int V_BLANK [NV] = '{40, 0, 1, 200};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_valid = 1'b0;
  logic line_ready;
  logic [NSLOT*GW-1:0] glyph_rows = '0;
  logic [NSLOT-1:0] slot_is_mark = '0;
  logic [2:0] mark_row = '0;
  logic [7:0] blank_len = '0;
  logic pix_out, line_done;

  int total = 0;
  int bad = 0;
  logic exp_px [0:511];
  int exp_len;

  always #10 clk = ~clk;

  ovl_glyph_serializer i_ovl_glyph_serializer (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
    .glyph_rows(glyph_rows), .slot_is_mark(slot_is_mark), .mark_row(mark_row),
    .blank_len(blank_len), .pix_out(pix_out), .line_done(line_done)
  );

  function automatic logic [4:0] row_of(input int seed, input int s);
    return 5'(((seed * 3) + (s * 11)) ^ (s << 2) ^ (seed >> 3));
  endfunction

  function automatic logic is_sep(input int s);
    return (s == 13 || s == 16 || s == 19);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build_expect(input int seed, input logic [2:0] mk, input int bl);
    int m = 0;
    exp_len = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (is_sep(s)) begin
        exp_px[exp_len++] = mk[2-m];
        m++;
      end else begin
        logic [4:0] r = row_of(seed, s);
        for (int b = 4; b >= 0; b--) exp_px[exp_len++] = r[b];
      end
      exp_px[exp_len++] = 1'b0;
      exp_px[exp_len++] = 1'b0;
      if (s == 10) for (int k = 0; k < bl; k++) exp_px[exp_len++] = 1'b0;
    end
  endtask

  // disturb: 0 none, 1 valid held high with new data (R8), 2 data changed, valid low (R9)
  task automatic run_line(input int seed, input logic [2:0] mk, input int bl,
                          input int disturb, input string req);
    int first_bad = -1;
    int act_b = 0;
    int exp_b = 0;
    int rdy_bad = 0;
    build_expect(seed, mk, bl);
    @(negedge clk);
    for (int s = 0; s < NSLOT; s++) begin
      glyph_rows[s*GW +: GW] = row_of(seed, s);
      slot_is_mark[s] = is_sep(s);
    end
    mark_row = mk;
    blank_len = 8'(bl);
    line_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < exp_len; k++) begin
      @(negedge clk);
      if (k == 0 && disturb != 1) line_valid = 1'b0;
      if (k == 2 && disturb != 0) begin
        glyph_rows = ~glyph_rows;
        slot_is_mark = ~slot_is_mark;
        mark_row = ~mark_row;
        blank_len = blank_len + 8'd7;
      end
      if (pix_out !== exp_px[k] && first_bad < 0) begin
        first_bad = k;
        act_b = int'(pix_out);
        exp_b = int'(exp_px[k]);
      end
      if (line_ready !== 1'b0 || line_done !== 1'b0) rdy_bad++;
    end
    total++;
    if (first_bad >= 0) begin
      bad++;
      $display("FAIL %s pixel %0d actual=%0d expected=%0d", req, first_bad, act_b, exp_b);
    end
    check(rdy_bad == 0, "R7 ready low while sending", rdy_bad, 0);
    @(negedge clk);
    line_valid = 1'b0;
    check(line_done === 1'b1 && line_ready === 1'b1, "R7 done after final pixel",
          int'({line_done, line_ready}), 3);
    @(negedge clk);
    check(line_done === 1'b0, "R7 done single cycle", int'(line_done), 0);
    check(pix_out === 1'b0, "R6 dark after line", int'(pix_out), 0);
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    #35;
    check(pix_out === 1'b0, "R1 pix at reset", int'(pix_out), 0);
    check(line_ready === 1'b1, "R1 ready at reset", int'(line_ready), 1);
    check(line_done === 1'b0, "R1 done at reset", int'(line_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R2 R3 R4 R5 across patterns and blank lengths
    for (int i = 0; i < NV; i++)
      run_line(V_SEED[i], 3'(V_MARK[i]), V_BLANK[i], 0, "R2/R3/R4/R5 stream");

    // R5: zero blank joins the groups directly
    run_line(0, 3'b111, 0, 0, "R5 zero blank");
    // R8: request held during line is ignored
    run_line(77, 3'b010, 12, 1, "R8 start ignored mid-line");
    // R9: data changes after acceptance have no effect
    run_line(140, 3'b101, 3, 2, "R9 inputs latched");

    // R6: idle stays dark with no request
    begin
      int lit = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (pix_out !== 1'b0 || line_ready !== 1'b1) lit++;
      end
      check(lit == 0, "R6 idle dark", lit, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule